// File: doc/BRIEF.md
# Floating-Point Multiply Special-Case Resolver

This block sits at the entry of a double-precision multiplier. It takes two 64-bit IEEE-754 binary64 operands and sorts each one into a class: zero, subnormal, normal, infinity, quiet NaN or signaling NaN. From those classes it decides whether the product is already settled without any mantissa work. When it is settled, the block drives a bypass result together with the invalid flag or an invalid trap request. When it is not settled, it leaves the bypass low. The product sign and the biased exponent sum are always present, so that the multiplier array downstream can start at once.

The block is purely combinational. It has no clock, no storage and no handshake. The multiplier pipeline owns the flow control and registers these outputs in its first stage. For that reason a valid/ready pair is not placed on this block's edge. Mantissa products, rounding, normalization of subnormals, and overflow and underflow handling all belong to later stages.

Top module: `fpm_special_resolver`

## Requirements
- R1: `res_sign` equals the XOR of the two operand sign bits (bit 63) for every input pair.
- R2: When operand A is a signaling NaN (exponent all ones, fraction nonzero, fraction bit 51 = 0), the result is operand A with fraction bit 51 set. Invalid is raised.
- R3: When operand A is a quiet NaN (fraction bit 51 = 1) and operand B is a signaling NaN, the result is operand B with bit 51 set. Invalid is raised.
- R4: When operand A is a quiet NaN and operand B is not a signaling NaN, the result is operand A unchanged. No exception signal is raised.
- R5: When operand A is not a NaN and operand B is a NaN, the result is operand B. It is quieted with invalid raised if B is signaling, and passed unchanged with no exception if B is quiet.
- R6: Infinity times zero, in either order and with neither operand a NaN, raises invalid. With the trap disabled, the result is 0x7FF8000000000000.
- R7: Infinity times a nonzero non-NaN value gives an infinity (exponent all ones, fraction 0) carrying the R1 sign, with no exception.
- R8: A zero operand times a finite value gives a zero carrying the R1 sign, with no exception.
- R9: When both operands are finite and nonzero, `byp_valid` is 0 and no exception is raised. `sum_exp` equals e_A + e_B − 1023 as a 13-bit two's-complement value, taken from the raw exponent fields.
- R10: With `inv_trap_en` = 1, every invalid case asserts `invalid_trap`, keeps `invalid_flag` at 0 and drives a bypass result of all zeros with `byp_valid` = 1. With `inv_trap_en` = 0, `invalid_trap` is never asserted.
- R11: Every special case (NaN, infinity or zero operand) asserts `byp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 64 | First operand, binary64 |
| op_b | input | 64 | Second operand, binary64 |
| inv_trap_en | input | 1 | Invalid-operation trap enable |
| byp_valid | output | 1 | Result is fixed by a special case |
| byp_result | output | 64 | Special-case result |
| res_sign | output | 1 | Product sign |
| sum_exp | output | 13 | Signed biased exponent sum for the normal path |
| invalid_flag | output | 1 | Invalid raised, trap disabled |
| invalid_trap | output | 1 | Invalid raised, trap requested |

## Verification
Each operand is drawn from one of six classes, so random pairs cover every class crossing, and the trap enable toggles at random across those pairs. Directed pairs target the four NaN orderings: sNaN/sNaN, qNaN/sNaN, qNaN/qNaN and number/sNaN. Each of these selects a different operand, or a different quieting, as the source of the result. Infinity against zero is run in both operand orders. Exponent extremes (1+1 and 2046+2046) confirm the signed span of the normal-path sum.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  typedef enum logic [2:0] {
    CL_ZERO   = 3'd0,
    CL_SUBN   = 3'd1,
    CL_NORM   = 3'd2,
    CL_INF    = 3'd3,
    CL_QNAN   = 3'd4,
    CL_SNAN   = 3'd5
  } fp_class_e;

  function automatic logic is_nan(input fp_class_e c);
    return (c == CL_QNAN) || (c == CL_SNAN);
  endfunction

  function automatic logic is_finite_nz(input fp_class_e c);
    return (c == CL_SUBN) || (c == CL_NORM);
  endfunction
endpackage

// File: rtl/fpm_classify.sv
module fpm_classify
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] op,
  output fp_class_e              cls
);
  localparam int QBIT = FRAC_W - 1;

  logic [EXP_W-1:0]  ex;
  logic [FRAC_W-1:0] fr;
  logic              ex_max, ex_min, fr_nz;

  assign ex     = op[EXP_W+FRAC_W-1:FRAC_W];
  assign fr     = op[FRAC_W-1:0];
  assign ex_max = &ex;
  assign ex_min = ~|ex;
  assign fr_nz  = |fr;

  always_comb begin
    if (ex_max) begin
      if (!fr_nz)        cls = CL_INF;
      else if (fr[QBIT]) cls = CL_QNAN;
      else               cls = CL_SNAN;
    end else if (ex_min) begin
      cls = fr_nz ? CL_SUBN : CL_ZERO;
    end else begin
      cls = CL_NORM;
    end
  end
endmodule

// File: rtl/fpm_nan_select.sv
module fpm_nan_select
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W+FRAC_W:0] op_a,
  input  logic [EXP_W+FRAC_W:0] op_b,
  input  fp_class_e              cls_a,
  input  fp_class_e              cls_b,
  output logic                   nan_hit,
  output logic                   nan_inv,
  output logic [EXP_W+FRAC_W:0]  nan_val
);
  localparam int W    = EXP_W + FRAC_W + 1;
  localparam int QBIT = FRAC_W - 1;
  localparam logic [W-1:0] QMASK = W'(1) << QBIT;

  always_comb begin
    nan_hit = 1'b1;
    nan_inv = 1'b0;
    nan_val = '0;
    if (cls_a == CL_SNAN) begin
      nan_inv = 1'b1;
      nan_val = op_a | QMASK;
    end else if (cls_a == CL_QNAN) begin
      if (cls_b == CL_SNAN) begin
        nan_inv = 1'b1;
        nan_val = op_b | QMASK;
      end else begin
        nan_val = op_a;
      end
    end else if (cls_b == CL_SNAN) begin
      nan_inv = 1'b1;
      nan_val = op_b | QMASK;
    end else if (cls_b == CL_QNAN) begin
      nan_val = op_b;
    end else begin
      nan_hit = 1'b0;
    end
  end
endmodule

// File: rtl/fpm_exp_sum.sv
module fpm_exp_sum #(
  parameter int EXP_W = 11
) (
  input  logic [EXP_W-1:0]        exp_a,
  input  logic [EXP_W-1:0]        exp_b,
  output logic signed [EXP_W+1:0] sum
);
  localparam int SW   = EXP_W + 2;
  localparam int BIAS = (1 << (EXP_W - 1)) - 1;

  logic [SW-1:0] raw;
  assign raw = SW'(exp_a) + SW'(exp_b) - SW'(BIAS);
  assign sum = $signed(raw);
endmodule

// File: rtl/fpm_special_resolver.sv
module fpm_special_resolver
  import fpm_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic                     [EXP_W+FRAC_W:0] op_a,
  input  logic                     [EXP_W+FRAC_W:0] op_b,
  input  logic                                      inv_trap_en,
  output logic                                      byp_valid,
  output logic                     [EXP_W+FRAC_W:0] byp_result,
  output logic                                      res_sign,
  output logic signed              [EXP_W+1:0]      sum_exp,
  output logic                                      invalid_flag,
  output logic                                      invalid_trap
);
  localparam int W    = EXP_W + FRAC_W + 1;
  localparam int QBIT = FRAC_W - 1;
  localparam logic [W-1:0] DEF_QNAN = {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  logic [W-1:0] ops [2];
  fp_class_e    cls [2];

  assign ops[0] = op_a;
  assign ops[1] = op_b;

  for (genvar i = 0; i < 2; i++) begin : g_cls
    fpm_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
      .op  (ops[i]),
      .cls (cls[i])
    );
  end

  logic         nan_hit, nan_inv;
  logic [W-1:0] nan_val;

  fpm_nan_select #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nan (
    .op_a    (op_a),
    .op_b    (op_b),
    .cls_a   (cls[0]),
    .cls_b   (cls[1]),
    .nan_hit (nan_hit),
    .nan_inv (nan_inv),
    .nan_val (nan_val)
  );

  fpm_exp_sum #(.EXP_W(EXP_W)) u_exp (
    .exp_a (op_a[W-2:FRAC_W]),
    .exp_b (op_b[W-2:FRAC_W]),
    .sum   (sum_exp)
  );

  logic inf_zero, any_inf, any_zero;

  assign res_sign = op_a[W-1] ^ op_b[W-1];
  assign inf_zero = ((cls[0] == CL_INF) && (cls[1] == CL_ZERO)) ||
                    ((cls[0] == CL_ZERO) && (cls[1] == CL_INF));
  assign any_inf  = (cls[0] == CL_INF) || (cls[1] == CL_INF);
  assign any_zero = (cls[0] == CL_ZERO) || (cls[1] == CL_ZERO);

  always_comb begin
    byp_valid    = 1'b1;
    byp_result   = '0;
    invalid_flag = 1'b0;
    invalid_trap = 1'b0;
    if (nan_hit) begin
      if (nan_inv && inv_trap_en) begin
        invalid_trap = 1'b1;
      end else begin
        invalid_flag = nan_inv;
        byp_result   = nan_val;
      end
    end else if (inf_zero) begin
      if (inv_trap_en) invalid_trap = 1'b1;
      else begin
        invalid_flag = 1'b1;
        byp_result   = DEF_QNAN;
      end
    end else if (any_inf) begin
      byp_result = {res_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    end else if (any_zero) begin
      byp_result = {res_sign, {(W-1){1'b0}}};
    end else begin
      byp_valid = 1'b0;
    end
  end
endmodule

// File: rtl/fpm_resolver_checker.sv
module fpm_resolver_checker #(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input logic [EXP_W+FRAC_W:0] op_a,
  input logic [EXP_W+FRAC_W:0] op_b,
  input logic                  inv_trap_en,
  input logic                  byp_valid,
  input logic [EXP_W+FRAC_W:0] byp_result,
  input logic                  res_sign,
  input logic                  invalid_flag,
  input logic                  invalid_trap
);
  localparam int W = EXP_W + FRAC_W + 1;

  logic a_nan, b_nan, a_inf, b_inf, a_zero, b_zero;
  assign a_inf  = (&op_a[W-2:FRAC_W]) && !(|op_a[FRAC_W-1:0]);
  assign b_inf  = (&op_b[W-2:FRAC_W]) && !(|op_b[FRAC_W-1:0]);
  assign a_nan  = (&op_a[W-2:FRAC_W]) && (|op_a[FRAC_W-1:0]);
  assign b_nan  = (&op_b[W-2:FRAC_W]) && (|op_b[FRAC_W-1:0]);
  assign a_zero = ~|op_a[W-2:0];
  assign b_zero = ~|op_b[W-2:0];

  always_comb begin
    assert_flag_trap_excl_R10: assert (!(invalid_flag && invalid_trap));
    if (!inv_trap_en)
      assert_no_trap_when_off_R10: assert (!invalid_trap);
    if (invalid_trap)
      assert_trap_zero_result_R10: assert (byp_valid && byp_result == '0);
    if (!a_nan && !b_nan && ((a_inf && b_zero) || (a_zero && b_inf)))
      assert_inf_zero_invalid_R6: assert (invalid_flag || invalid_trap);
    if (a_nan || b_nan || a_inf || b_inf || a_zero || b_zero)
      assert_special_bypass_R11: assert (byp_valid);
    if (!a_nan && !b_nan && !a_inf && !b_inf && !a_zero && !b_zero)
      assert_normal_path_R9: assert (!byp_valid && !invalid_flag && !invalid_trap);
    if (byp_valid && !a_nan && !b_nan && !invalid_flag && !invalid_trap)
      assert_result_sign_R1: assert (byp_result[W-1] == res_sign);
    if (!a_nan && !b_nan && !a_inf && !b_inf && (a_zero || b_zero))
      assert_zero_result_R8: assert (byp_result[W-2:0] == '0 && !invalid_flag && !invalid_trap);
  end
endmodule

bind fpm_special_resolver fpm_resolver_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .op_a         (op_a),
  .op_b         (op_b),
  .inv_trap_en  (inv_trap_en),
  .byp_valid    (byp_valid),
  .byp_result   (byp_result),
  .res_sign     (res_sign),
  .invalid_flag (invalid_flag),
  .invalid_trap (invalid_trap)
);

// File: tb/tb_fpm_special_resolver.sv
module tb_fpm_special_resolver;
  logic        clk = 1'b0;
  always #5 clk = ~clk;

  logic [63:0] op_a = '0, op_b = '0;
  logic        inv_trap_en = 1'b0;
  logic        byp_valid, invalid_flag, invalid_trap, res_sign;
  logic [63:0] byp_result;
  logic signed [12:0] sum_exp;

  int checks = 0, errors = 0;

  fpm_special_resolver dut (
    .op_a(op_a), .op_b(op_b), .inv_trap_en(inv_trap_en),
    .byp_valid(byp_valid), .byp_result(byp_result), .res_sign(res_sign),
    .sum_exp(sum_exp), .invalid_flag(invalid_flag), .invalid_trap(invalid_trap)
  );

  localparam logic [63:0] QB = 64'h0008_0000_0000_0000;

  function automatic logic f_nan(input logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] != 0);
  endfunction
  function automatic logic f_inf(input logic [63:0] v);
    return (v[62:52] == 11'h7FF) && (v[51:0] == 0);
  endfunction
  function automatic logic f_zero(input logic [63:0] v);
    return v[62:0] == 0;
  endfunction

  function automatic logic [63:0] gen(input int c);
    logic [63:0] v;
    v = {$urandom, $urandom};
    case (c)
      0: v[62:0] = '0;
      1: begin v[62:52] = '0; if (v[51:0] == 0) v[0] = 1'b1; end
      2: begin v[62:52] = 11'($urandom_range(2046, 1)); end
      3: begin v[62:52] = 11'h7FF; v[51:0] = '0; end
      4: begin v[62:52] = 11'h7FF; v[51] = 1'b1; end
      default: begin v[62:52] = 11'h7FF; v[51] = 1'b0; if (v[50:0] == 0) v[3] = 1'b1; end
    endcase
    return v;
  endfunction

  task automatic model(input logic [63:0] a, input logic [63:0] b, input logic te,
                       output logic ev, output logic [63:0] er, output logic ef,
                       output logic et, output string req);
    logic inv;
    logic [63:0] nv;
    ev = 1'b1; er = '0; ef = 1'b0; et = 1'b0; inv = 1'b0; nv = '0;
    if (f_nan(a) || f_nan(b)) begin
      if (f_nan(a) && !a[51])      begin inv = 1; nv = a | QB; req = "R2"; end
      else if (f_nan(a)) begin
        if (f_nan(b) && !b[51])    begin inv = 1; nv = b | QB; req = "R3"; end
        else                       begin nv = a; req = "R4"; end
      end else if (!b[51])         begin inv = 1; nv = b | QB; req = "R5"; end
      else                         begin nv = b; req = "R5"; end
      if (inv && te) et = 1;
      else begin ef = inv; er = nv; end
    end else if ((f_inf(a) && f_zero(b)) || (f_zero(a) && f_inf(b))) begin
      req = te ? "R10" : "R6";
      if (te) et = 1; else begin ef = 1; er = 64'h7FF8_0000_0000_0000; end
    end else if (f_inf(a) || f_inf(b)) begin
      req = "R7"; er = {a[63]^b[63], 11'h7FF, 52'h0};
    end else if (f_zero(a) || f_zero(b)) begin
      req = "R8"; er = {a[63]^b[63], 63'h0};
    end else begin
      req = "R9"; ev = 1'b0;
    end
  endtask

  task automatic apply(input logic [63:0] a, input logic [63:0] b, input logic te);
    logic ev, ef, et;
    logic [63:0] er;
    logic signed [12:0] es;
    string req;
    @(negedge clk);
    op_a = a; op_b = b; inv_trap_en = te;
    #2;
    model(a, b, te, ev, er, ef, et, req);
    es = 13'(int'(a[62:52]) + int'(b[62:52]) - 1023);
    checks++;
    if (res_sign !== (a[63] ^ b[63])) begin
      errors++; $display("FAIL R1 sign act=%b exp=%b", res_sign, a[63]^b[63]);
    end
    checks++;
    if (byp_valid !== ev || invalid_flag !== ef || invalid_trap !== et ||
        (ev && byp_result !== er)) begin
      errors++;
      $display("FAIL %s a=%h b=%h te=%b act v%b r%h f%b t%b exp v%b r%h f%b t%b",
               req, a, b, te, byp_valid, byp_result, invalid_flag, invalid_trap,
               ev, er, ef, et);
    end
    if (!ev) begin
      checks++;
      if (sum_exp !== es) begin
        errors++; $display("FAIL R9 sum_exp act=%0d exp=%0d", sum_exp, es);
      end
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // startup state: zero x zero, trap off
    apply(64'h0, 64'h0, 1'b0);                                         // R8
    apply(64'h7FF4_0000_0000_0001, 64'h7FF2_0000_0000_0000, 1'b0);     // R2 sNaN/sNaN
    apply(64'hFFF8_0000_0000_00AA, 64'h7FF1_0000_0000_0000, 1'b0);     // R3
    apply(64'h7FF8_0000_0000_0011, 64'h7FF8_0000_0000_0022, 1'b0);     // R4
    apply(64'h7FF8_0000_0000_0011, 64'h3FF0_0000_0000_0000, 1'b0);     // R4
    apply(64'hBFF0_0000_0000_0000, 64'h7FF0_0000_0000_0005, 1'b0);     // R5 sNaN
    apply(64'h0000_0000_0000_0000, 64'hFFFC_0000_0000_0000, 1'b0);     // R5 qNaN
    apply(64'h7FF0_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0);     // R6
    apply(64'h0000_0000_0000_0000, 64'hFFF0_0000_0000_0000, 1'b0);     // R6 swapped
    apply(64'h7FF0_0000_0000_0000, 64'h0000_0000_0000_0000, 1'b1);     // R10
    apply(64'h7FF4_0000_0000_0000, 64'h3FF0_0000_0000_0000, 1'b1);     // R10
    apply(64'hFFF0_0000_0000_0000, 64'h0000_0000_0000_0001, 1'b0);     // R7
    apply(64'h8000_0000_0000_0000, 64'h4000_0000_0000_0000, 1'b0);     // R8
    apply(64'h0010_0000_0000_0000, 64'h0010_0000_0000_0000, 1'b0);     // R9 min
    apply(64'h7FEF_FFFF_FFFF_FFFF, 64'hFFEF_FFFF_FFFF_FFFF, 1'b0);     // R9 max
    apply(64'h0000_0000_0000_0001, 64'h3FF0_0000_0000_0000, 1'b0);     // R9 subnormal
    for (int i = 0; i < 2000; i++)
      apply(gen($urandom_range(5, 0)), gen($urandom_range(5, 0)), 1'($urandom));  // R11 mix
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule